// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block holds a bank of hardware instruction breakpoints and compares every instruction fetch address against all of them in parallel. Each breakpoint has a 64-bit address register and a 64-bit control register. Software loads both through an indexed register port and can read them back. A breakpoint fires only when four conditions hold together: it is enabled, its type is one of the two address-match types, its byte-lane select is non-zero, and the fetch address equals its computed address exactly.

The fetch address arrives on a valid-qualified stream. The block accepts a beat in every cycle and never applies back-pressure, so it has no ready output. On a valid beat, the hit flag and the index of the lowest matching breakpoint follow combinationally in the same cycle. The control and register pins are plain level signals.

Top module: `bkpt_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every address and control register, so each reads back zero and no breakpoint can fire.
- R2: On a control write, bit 6 stores a copy of write bit 5 and bit 8 stores a copy of write bit 7, whatever values were written to bits 6 and 8. All other control bits store as written, and address-register writes store all 64 bits unchanged. Read data shows the stored value of the register picked by `reg_idx` and `reg_sel` (0 = address, 1 = control).
- R3: A breakpoint whose control bit 0 (enable) is clear never fires.
- R4: Control bits [23:20] give the type. Only type 0 and type 1 may fire. Every other type value, including 2, 4, 8 and 15, never fires.
- R5: The compare address takes address-register bits [48:0] and copies bit 48 into bits [63:49]. Bits [1:0] are forced to zero.
- R6: Control bits [8:5] form the byte-lane select. A stored value of 0000 never fires. A value of 0011 or 1111 fires at the base address. A value of 1100 fires at the base address plus 2.
- R7: A hit requires exact equality with the computed address. A fetch that starts at another byte of the covered range does not fire.
- R8: When several breakpoints fire on the same fetch, `hit` is asserted once and `hit_idx` reports the lowest index.
- R9: A register write takes effect from the clock edge that captures it. The hit outputs are combinational from the fetch inputs and the stored state, and they stay stable while neither changes.
- R10: When `fetch_valid` is low, `hit` is low. Whenever `hit` is low, `hit_idx` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Breakpoint index for write and read |
| reg_sel | input | 1 | 0 selects the address register, 1 selects the control register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Stored value of the selected register |
| fetch_valid | input | 1 | Fetch address beat is valid |
| fetch_addr | input | 64 | Instruction fetch address |
| hit | output | 1 | At least one breakpoint matches the valid fetch |
| hit_idx | output | 4 | Lowest matching breakpoint index, zero when no hit |

## Verification
The assertions assume that software never has a register write and a reset in the same cycle with any meaning. They also assume that the fetch inputs are held steady whenever stability of the outputs is judged. The bench drives all inputs on the falling clock edge, so writes and fetch changes are registered only at the rising edge. Reset is held for several cycles before any traffic. The bench samples outputs one nanosecond after it drives inputs, or at the following falling edge, so combinational results have settled whenever the assertion on stable outputs is checked.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_SEL_LO  = 5;
  localparam int CTL_SEL_W   = 4;
  localparam int CTL_TYPE_LO = 20;
  localparam int CTL_TYPE_W  = 4;

  localparam logic [CTL_TYPE_W-1:0] TYPE_ADDR_UNLINKED = 4'd0;
  localparam logic [CTL_TYPE_W-1:0] TYPE_ADDR_LINKED   = 4'd1;

  localparam logic [CTL_SEL_W-1:0] SEL_OFF   = 4'b0000;
  localparam logic [CTL_SEL_W-1:0] SEL_UPPER = 4'b1100;

  typedef enum logic {
    REG_ADDR = 1'b0,
    REG_CTRL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/bkpt_slot.sv
module bkpt_slot
  import bkpt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int VA_MSB = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              match
);
  localparam int EXT_W = DATA_W - VA_MSB - 1;

  logic [DATA_W-1:0]     ctrl_next;
  logic [DATA_W-1:0]     base_addr;
  logic [DATA_W-1:0]     bp_addr;
  logic [CTL_SEL_W-1:0]  lane_sel;
  logic [CTL_TYPE_W-1:0] bp_type;
  logic                  type_fires;

  // byte-lane pairs are forced together when the control word is stored
  always_comb begin
    ctrl_next                 = wdata;
    ctrl_next[CTL_SEL_LO + 1] = wdata[CTL_SEL_LO];
    ctrl_next[CTL_SEL_LO + 3] = wdata[CTL_SEL_LO + 2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_addr) addr_q <= wdata;
      if (wr_ctrl) ctrl_q <= ctrl_next;
    end
  end

  assign lane_sel = ctrl_q[CTL_SEL_LO +: CTL_SEL_W];
  assign bp_type  = ctrl_q[CTL_TYPE_LO +: CTL_TYPE_W];

  assign base_addr = {{EXT_W{addr_q[VA_MSB]}}, addr_q[VA_MSB:2], 2'b00};
  assign bp_addr   = (lane_sel == SEL_UPPER) ? base_addr + DATA_W'(2) : base_addr;

  assign type_fires = (bp_type == TYPE_ADDR_UNLINKED) || (bp_type == TYPE_ADDR_LINKED);

  assign match = ctrl_q[CTL_EN_BIT] && type_fires && (lane_sel != SEL_OFF)
                 && (fetch_addr == bp_addr);
endmodule

// File: rtl/bkpt_prio.sv
module bkpt_prio #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_BP = 16,
  parameter int DATA_W = 64,
  parameter int VA_MSB = 48,
  localparam int IDX_W = $clog2(NUM_BP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fetch_valid,
  input  logic [DATA_W-1:0] fetch_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [DATA_W-1:0] addr_arr [NUM_BP];
  logic [DATA_W-1:0] ctrl_arr [NUM_BP];
  logic [NUM_BP-1:0] match_vec;
  logic              any_match;
  logic [IDX_W-1:0]  low_idx;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_slot
    logic sel_here;
    assign sel_here = reg_we && (reg_idx == IDX_W'(g));
    bkpt_slot #(.DATA_W(DATA_W), .VA_MSB(VA_MSB)) slot_i (
      .clk        (clk),
      .rst        (rst),
      .wr_addr    (sel_here && (reg_sel == REG_ADDR)),
      .wr_ctrl    (sel_here && (reg_sel == REG_CTRL)),
      .wdata      (reg_wdata),
      .fetch_addr (fetch_addr),
      .addr_q     (addr_arr[g]),
      .ctrl_q     (ctrl_arr[g]),
      .match      (match_vec[g])
    );
  end

  bkpt_prio #(.N(NUM_BP), .IDX_W(IDX_W)) prio_i (
    .req (match_vec),
    .any (any_match),
    .idx (low_idx)
  );

  assign reg_rdata = (reg_sel == REG_CTRL) ? ctrl_arr[reg_idx] : addr_arr[reg_idx];
  assign hit       = fetch_valid && any_match;
  assign hit_idx   = hit ? low_idx : '0;
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [IDX_W-1:0]  reg_idx,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              fetch_valid,
  input logic [DATA_W-1:0] fetch_addr,
  input logic              hit,
  input logic [IDX_W-1:0]  hit_idx
);
  // R1: the edge after reset leaves every breakpoint disabled
  always @(posedge clk) begin
    if ($past(rst)) begin
      p_reset_quiet_r1: assert (!hit) else $error("hit right after reset");
    end
  end

  // R2: a control readback always shows the paired lane bits
  p_lane_pairs_r2: assert property (@(posedge clk) disable iff (rst)
    reg_sel |-> (reg_rdata[6] == reg_rdata[5]) && (reg_rdata[8] == reg_rdata[7]));

  // R5, R6: every fire lands on an even address
  p_even_hit_r5: assert property (@(posedge clk) disable iff (rst)
    hit |-> !fetch_addr[0]);

  // R9: no write and steady fetch inputs give steady outputs
  p_steady_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(reg_we) && $stable(fetch_addr) && $stable(fetch_valid))
      |-> ($stable(hit) && $stable(hit_idx)));

  // R10: no valid beat, no hit
  p_no_beat_r10: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |-> !hit);

  // R10: the index is zero whenever nothing fires
  p_idx_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (hit_idx == '0));
endmodule

bind bkpt_unit bkpt_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/bkpt_unit_tb_top.sv
`timescale 1ns/1ps
module bkpt_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [3:0]  reg_idx;
  logic        reg_sel;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        fetch_valid;
  logic [63:0] fetch_addr;
  logic        hit;
  logic [3:0]  hit_idx;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bkpt_unit dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .hit(hit), .hit_idx(hit_idx)
  );

  typedef struct packed {
    logic [3:0]  slot;
    logic [63:0] addr;
    logic [63:0] ctrl;
    logic [63:0] fetch;
    logic        exp_hit;
    logic [3:0]  exp_idx;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  64'h1000, 64'h0000_0061, 64'h1000, 1'b1, 4'd3,  8'd4},  // R4 type 0
    '{4'd3,  64'h1000, 64'h0010_0061, 64'h1000, 1'b1, 4'd3,  8'd4},  // R4 type 1
    '{4'd5,  64'h1000, 64'h0020_0061, 64'h1000, 1'b0, 4'd0,  8'd4},  // R4 type 2
    '{4'd5,  64'h1000, 64'h0040_0061, 64'h1000, 1'b0, 4'd0,  8'd4},  // R4 type 4
    '{4'd5,  64'h1000, 64'h0080_0061, 64'h1000, 1'b0, 4'd0,  8'd4},  // R4 type 8
    '{4'd5,  64'h1000, 64'h00F0_0061, 64'h1000, 1'b0, 4'd0,  8'd4},  // R4 type 15
    '{4'd0,  64'h1000, 64'h0000_0060, 64'h1000, 1'b0, 4'd0,  8'd3},  // R3 enable clear
    '{4'd7,  64'h1000, 64'h0000_0181, 64'h1002, 1'b1, 4'd7,  8'd6},  // R6 upper pair
    '{4'd7,  64'h1000, 64'h0000_0181, 64'h1000, 1'b0, 4'd0,  8'd7},  // R7 base misses
    '{4'd7,  64'h1000, 64'h0000_01E1, 64'h1000, 1'b1, 4'd7,  8'd6},  // R6 all lanes
    '{4'd7,  64'h1000, 64'h0000_01E1, 64'h1002, 1'b0, 4'd0,  8'd7},  // R7 inside range
    '{4'd7,  64'h1000, 64'h0000_0001, 64'h1000, 1'b0, 4'd0,  8'd6},  // R6 lanes off
    '{4'd15, 64'h1003, 64'h0000_0061, 64'h1000, 1'b1, 4'd15, 8'd5},  // R5 low bits dropped
    '{4'd15, 64'h1003, 64'h0000_0061, 64'h1003, 1'b0, 4'd0,  8'd7},  // R7 raw value misses
    '{4'd15, 64'h0001_0000_0000_0000, 64'h61, 64'hFFFF_0000_0000_0000, 1'b1, 4'd15, 8'd5}, // R5 sign copy
    '{4'd15, 64'hABCC_0000_0000_1000, 64'h61, 64'h1000, 1'b1, 4'd15, 8'd5},  // R5 upper bits ignored
    '{4'd15, 64'h1000, 64'h0000_0021, 64'h1000, 1'b1, 4'd15, 8'd2},  // R2 bit5 pairs
    '{4'd15, 64'h1000, 64'h0000_0081, 64'h1002, 1'b1, 4'd15, 8'd2}   // R2 bit7 pairs
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic sel, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic sel);
    @(negedge clk);
    reg_idx = idx; reg_sel = sel;
    #1;
  endtask

  task automatic fetch(input logic [63:0] a);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a;
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; reg_we = 1'b0; reg_idx = '0; reg_sel = 1'b0; reg_wdata = '0;
    fetch_valid = 1'b0; fetch_addr = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: all registers zero after reset, nothing fires at address 0
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), 1'b0); check("R1 addr reg", reg_rdata, 64'h0);
      rd(4'(i), 1'b1); check("R1 ctrl reg", reg_rdata, 64'h0);
    end
    fetch(64'h0);
    check("R1 no hit", {63'h0, hit}, 64'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      wr(VECS[v].slot, 1'b0, VECS[v].addr);
      wr(VECS[v].slot, 1'b1, VECS[v].ctrl);
      fetch(VECS[v].fetch);
      check($sformatf("R%0d vec%0d hit", VECS[v].req, v), {63'h0, hit}, {63'h0, VECS[v].exp_hit});
      check($sformatf("R%0d vec%0d idx", VECS[v].req, v), {60'h0, hit_idx}, {60'h0, VECS[v].exp_idx});
      wr(VECS[v].slot, 1'b1, 64'h0);
    end

    // R2: stored control copies, value raw
    wr(4'd4, 1'b1, 64'h0000_0000_0000_00A1);
    rd(4'd4, 1'b1); check("R2 pair set", reg_rdata, 64'h0000_0000_0000_01E1);
    wr(4'd4, 1'b1, 64'hFFFF_0000_0000_0141);
    rd(4'd4, 1'b1); check("R2 pair clear", reg_rdata, 64'hFFFF_0000_0000_0001);
    wr(4'd4, 1'b0, 64'hDEAD_BEEF_0123_4567);
    rd(4'd4, 1'b0); check("R2 addr raw", reg_rdata, 64'hDEAD_BEEF_0123_4567);
    wr(4'd4, 1'b1, 64'h0);

    // R8: two slots on one address
    wr(4'd9, 1'b0, 64'h2000); wr(4'd9, 1'b1, 64'h61);
    wr(4'd2, 1'b0, 64'h2000); wr(4'd2, 1'b1, 64'h61);
    fetch(64'h2000);
    check("R8 hit", {63'h0, hit}, 64'h1);
    check("R8 lowest idx", {60'h0, hit_idx}, 64'd2);
    wr(4'd2, 1'b1, 64'h0);
    #1;
    check("R8 next idx", {60'h0, hit_idx}, 64'd9);

    // R10: valid low suppresses a matching address
    @(negedge clk); fetch_valid = 1'b0; #1;
    check("R10 no valid hit", {63'h0, hit}, 64'h0);
    check("R10 no valid idx", {60'h0, hit_idx}, 64'h0);
    wr(4'd9, 1'b1, 64'h0);

    // R9: write not visible before the capturing edge
    wr(4'd6, 1'b0, 64'h3000);
    fetch(64'h3000);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 4'd6; reg_sel = 1'b1; reg_wdata = 64'h61;
    #1;
    check("R9 before edge", {63'h0, hit}, 64'h0);
    @(negedge clk); reg_we = 1'b0; #1;
    check("R9 after edge", {63'h0, hit}, 64'h1);
    check("R9 after edge idx", {60'h0, hit_idx}, 64'd6);

    // R1: reset mid-run drops the armed slot
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    check("R1 reset drops hit", {63'h0, hit}, 64'h0);
    rd(4'd6, 1'b0); check("R1 reset clears addr", reg_rdata, 64'h0);

    finish_run();
  end
endmodule